// File: doc/BRIEF.md
# Oversampled Tristate Phase-Frequency Detector with Delayed Reset

This block compares two edge streams, a reference and a feedback divider output, and produces the UP and DOWN pulses that would drive a charge pump. Both edge streams are asynchronous to the system clock. They are brought into the clock domain by a synchronizer, and their rising edges are found by comparing successive samples. A rising reference edge raises an internal UP flag, and a rising divider edge raises an internal DOWN flag.

When both flags are high, a reset timer starts. It clears both flags only after a programmable number of system-clock cycles. Because of this, every pulse lasts at least that long, which removes the dead zone that very short pulses would cause. An edge that arrives while the reset is pending is held and applied at the moment of clearing, so it is not lost.

An offset mode changes the shape of the output. In this mode UP is driven only during the reset interval, so its width is always the programmed delay and it never starts before DOWN. All phase information is then carried by the width of DOWN.

Top module: `pfd_delayed_reset`

## Requirements
- R1: A rising edge on `ref_in` sets the UP flag and a rising edge on `div_in` sets the DOWN flag. A level change on an input that is first sampled by clock edge E0 shows at the flag two edges later (E2). For an input changed just after a falling edge, that is the third following falling edge.
- R2: When both flags are high, both are cleared on the clock edge that lies D edges after the edge that made them both high. D is `dly_cnt`, and a value of 0 acts as 1.
- R3: In normal mode (`offset_mode`=0), with the reference leading by p cycles, UP is high for p+D cycles and DOWN for D cycles. With the reference lagging by p cycles, DOWN is high for p+D cycles and UP for D cycles. With zero phase error, both are high for D cycles.
- R4: A rising edge of one input while its own flag is already high and the other flag is low has no effect. No extra pulse is produced and the pulse width is not changed.
- R5: A rising edge that arrives while both flags are high is held. At the clearing edge it sets its flag again, so that output stays high while the other output falls.
- R6: In offset mode (`offset_mode`=1), UP is high exactly while both flags are high. UP therefore lasts D cycles and never rises before DOWN. If the divider leads by p cycles, DOWN lasts p+D cycles. If the reference leads, DOWN lasts D cycles and starts together with UP.
- R7: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference edge stream, asynchronous |
| div_in | input | 1 | Divider edge stream, asynchronous |
| dly_cnt | input | CNT_W | Reset delay D in clock cycles (0 treated as 1) |
| offset_mode | input | 1 | 1 selects the fixed-width UP offset mode |
| up_o | output | 1 | UP pulse to the charge pump |
| dn_o | output | 1 | DOWN pulse to the charge pump |

## Verification
The detector is driven with edge pairs at known cycle offsets in both modes. A leading reference, a lagging reference and zero phase error each give a distinct expected width split between UP and DOWN, so a design that swapped the sides, ignored the delay or clipped the minimum width would produce different counts. Delays of 0, 1 and larger values separate the clamping of a zero count from ordinary counting. A repeated reference edge before the divider edge separates a design that ignores the extra edge from one that starts a new pulse. A second edge inside the reset interval separates a design that holds that edge from one that drops it.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_OFFSET = 1'b1
   } pfd_mode_e;

   // terminal count of the reset timer: a zero request behaves as one cycle
   function automatic int unsigned reset_limit(input int unsigned dly);
      return (dly == 0) ? 0 : dly - 1;
   endfunction
endpackage

// File: rtl/pfd_edge_sync.sv
`timescale 1ns/1ps
module pfd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   localparam int CHAIN_W = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pfd_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   // chain[STAGES-1:0] synchronizes, chain[STAGES] keeps the previous sample
   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN_W-2:0], din};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

   // a single rising edge yields a one-cycle event
   assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/pfd_reset_timer.sv
`timescale 1ns/1ps
module pfd_reset_timer
   import pfd_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             window,
   input  logic [CNT_W-1:0] dly,
   output logic             clr
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("pfd_reset_timer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit = CNT_W'(reset_limit(int'(dly)));
   assign clr   = window && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (window) cnt <= cnt + 1'b1;
      else             cnt <= '0;
   end

   // the both-high interval persists until the timer releases it
   assert_window_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      window && !clr |=> window);
endmodule

// File: rtl/pfd_flag.sv
`timescale 1ns/1ps
module pfd_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   input  logic window,
   input  logic clr,
   output logic flag
);
   logic held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         held <= 1'b0;
      end else if (clr) begin
         flag <= held | rise;
         held <= 1'b0;
      end else if (window) begin
         held <= held | rise;
      end else if (rise) begin
         flag <= 1'b1;
      end
   end

   assert_set_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rise && !window |=> flag);
   assert_fall_on_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(clr));
   assert_held_applied_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr && rise |=> flag);
endmodule

// File: rtl/pfd_delayed_reset.sv
`timescale 1ns/1ps
module pfd_delayed_reset
   import pfd_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit ALLOW_OFFSET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_in,
   input  logic             div_in,
   input  logic [CNT_W-1:0] dly_cnt,
   input  logic             offset_mode,
   output logic             up_o,
   output logic             dn_o
);
   logic ref_rise, div_rise;
   logic up_flag, dn_flag;
   logic window, clr;

   pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk(clk), .rst_n(rst_n), .din(ref_in), .rise(ref_rise));
   pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_div_sync (
      .clk(clk), .rst_n(rst_n), .din(div_in), .rise(div_rise));

   assign window = up_flag & dn_flag;

   pfd_reset_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .window(window), .dly(dly_cnt), .clr(clr));

   pfd_flag u_up_flag (
      .clk(clk), .rst_n(rst_n), .rise(ref_rise), .window(window),
      .clr(clr), .flag(up_flag));
   pfd_flag u_dn_flag (
      .clk(clk), .rst_n(rst_n), .rise(div_rise), .window(window),
      .clr(clr), .flag(dn_flag));

   generate
      if (ALLOW_OFFSET) begin : g_offset
         pfd_mode_e mode;
         assign mode = pfd_mode_e'(offset_mode);
         assign up_o = (mode == MODE_OFFSET) ? window : up_flag;
         assign dn_o = dn_flag;

         assert_up_inside_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
            offset_mode && up_o |-> dn_o);
      end else begin : g_plain
         assign up_o = up_flag;
         assign dn_o = dn_flag;
      end
   endgenerate

   assert_ignore_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      up_flag && !dn_flag && ref_rise |=> up_flag && !dn_flag || div_rise && !$past(div_rise) || up_flag);
   always_comb begin
      if (!rst_n) assert_reset_low_R7: assert (!up_flag && !dn_flag);
   end
endmodule

// File: tb/pfd_delayed_reset_test.sv
`timescale 1ns/1ps
module pfd_delayed_reset_test;
   localparam int CNT_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_in = 1'b0, div_in = 1'b0, offset_mode = 1'b0;
   logic [CNT_W-1:0] dly_cnt = '0;
   logic up_o, dn_o;

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;
   int up_cnt, dn_cnt, up_first, dn_first, up_rises, dn_rises;

   always #5 clk = ~clk;

   pfd_delayed_reset #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in),
      .dly_cnt(dly_cnt), .offset_mode(offset_mode), .up_o(up_o), .dn_o(dn_o));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ref high for [r1,r1+rl) and [r2,r2+rl); div for [d1,d1+dl) and [d2,d2+dl)
   task automatic capture(input int r1, input int r2, input int rl,
                          input int d1, input int d2, input int dl,
                          input int dly, input bit mode);
      logic up_prev = 1'b0, dn_prev = 1'b0;
      dly_cnt = CNT_W'(dly);
      offset_mode = mode;
      up_cnt = 0; dn_cnt = 0; up_first = -1; dn_first = -1; up_rises = 0; dn_rises = 0;
      for (int k = 0; k < 70; k++) begin
         @(negedge clk);
         if (up_o) begin
            up_cnt++;
            if (up_first < 0) up_first = k;
            if (!up_prev) up_rises++;
         end
         if (dn_o) begin
            dn_cnt++;
            if (dn_first < 0) dn_first = k;
            if (!dn_prev) dn_rises++;
         end
         up_prev = up_o; dn_prev = dn_o;
         ref_in = (k >= r1 && k < r1 + rl) || (r2 >= 0 && k >= r2 && k < r2 + rl);
         div_in = (k >= d1 && k < d1 + dl) || (d2 >= 0 && k >= d2 && k < d2 + dl);
      end
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      ref_in = 1'b1; div_in = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7", "up during reset", int'(up_o), 0);
      chk("R7", "dn during reset", int'(dn_o), 0);
      ref_in = 1'b0; div_in = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_ref_leads;
      capture(2, -1, 20, 7, -1, 20, 3, 1'b0);
      chk("R1", "up latency", up_first, 5);
      chk("R1", "dn latency", dn_first, 10);
      chk("R3", "lead up width", up_cnt, 8);
      chk("R3", "lead dn width", dn_cnt, 3);
   endtask

   task automatic t_ref_lags;
      capture(6, -1, 20, 2, -1, 20, 2, 1'b0);
      chk("R3", "lag up width", up_cnt, 2);
      chk("R3", "lag dn width", dn_cnt, 6);
      chk("R3", "lag dn first", dn_first, 5);
   endtask

   task automatic t_zero_error;
      capture(3, -1, 20, 3, -1, 20, 5, 1'b0);
      chk("R3", "zero up width", up_cnt, 5);
      chk("R3", "zero dn width", dn_cnt, 5);
   endtask

   task automatic t_small_delays;
      capture(3, -1, 20, 3, -1, 20, 0, 1'b0);
      chk("R2", "delay 0 up width", up_cnt, 1);
      chk("R2", "delay 0 dn width", dn_cnt, 1);
      capture(3, -1, 20, 4, -1, 20, 1, 1'b0);
      chk("R2", "delay 1 up width", up_cnt, 2);
      chk("R2", "delay 1 dn width", dn_cnt, 1);
   endtask

   task automatic t_repeat_ignored;
      capture(0, 6, 3, 10, -1, 20, 2, 1'b0);
      chk("R4", "up pulses", up_rises, 1);
      chk("R4", "up width", up_cnt, 12);
      chk("R4", "dn width", dn_cnt, 2);
   endtask

   task automatic t_held_edge;
      capture(0, 2, 1, 0, 20, 1, 4, 1'b0);
      chk("R5", "up pulses", up_rises, 1);
      chk("R5", "up width", up_cnt, 24);
      chk("R5", "dn pulses", dn_rises, 2);
      chk("R5", "dn width", dn_cnt, 8);
   endtask

   task automatic t_offset_mode;
      capture(2, -1, 20, 7, -1, 20, 3, 1'b1);
      chk("R6", "ref lead up width", up_cnt, 3);
      chk("R6", "ref lead dn width", dn_cnt, 3);
      chk("R6", "ref lead same start", up_first - dn_first, 0);
      capture(6, -1, 20, 2, -1, 20, 3, 1'b1);
      chk("R6", "div lead up width", up_cnt, 3);
      chk("R6", "div lead dn width", dn_cnt, 7);
      chk("R6", "div lead up after dn", up_first - dn_first, 4);
      capture(3, -1, 20, 3, -1, 20, 2, 1'b1);
      chk("R6", "zero up width", up_cnt, 2);
      chk("R6", "zero dn width", dn_cnt, 2);
   endtask

   initial begin
      t_reset();
      t_ref_leads();
      t_ref_lags();
      t_zero_error();
      t_small_delays();
      t_repeat_ignored();
      t_held_edge();
      t_offset_mode();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule